// File: doc/BRIEF.md
# Framed Serial Word Receiver

This block turns a framed synchronous bit stream into parallel words for a host processor or a DMA engine. It watches a frame strobe and a serial data line, both sampled on the falling edge of the receive clock. When a frame strobe is accepted, the block skips a chosen number of bit clocks. It then collects a word of configurable length, with the most significant bit arriving first.

A finished word passes through three registers. The shift register collects the bits. The holding buffer keeps a finished word until the output register is free. The output register is what the host reads. On the step from buffer to output register, the word is right-justified, and its unused upper bits are filled with zeros or with copies of its top bit. A ready flag tells the host that the output register holds an unread word. Because of the holding buffer, one word can be parked while the next word is still shifting in. A sticky overrun flag records any word that was lost because both stages were full.

Top module: `serial_rx_port`

## Requirements
- R1: A low `rst_n` sampled at a falling clock edge clears `ready`, `overrun`, `rd_data` and both internal word stages, and returns the receiver to waiting for a frame strobe.
- R2: While idle, the receiver ignores `sdata` until `fsync` is seen high at a falling edge. Serial activity without a strobe never raises `ready`.
- R3: `cfg_delay` sets the gap between the strobe and the first data bit. For 0, the first bit is taken on the strobe edge. For 1, it is taken one edge later. For 2, it is taken two edges later. The value 3 behaves like 2.
- R4: A word is taken most significant bit first. Its length is `cfg_wlen`, limited to the range 8..32: smaller values act as 8 and larger values act as 32.
- R5: Suppose the last bit of a word is taken at edge E and both stages are empty. After E, `ready` is still low. After edge E+1, `ready` is high and `rd_data` holds the word.
- R6: The word occupies bits [len-1:0] of `rd_data`. When `cfg_sign_ext` is 0, bits 31..len are 0. When `cfg_sign_ext` is 1, bits 31..len copy bit len-1.
- R7: `rd_en` high at an edge while `ready` is high and the buffer is empty clears `ready` after that edge. `rd_en` has no effect while `ready` is low.
- R8: A word that completes while the output register is still unread is held in the buffer. It moves into the output register on the same edge that the host read is taken, so `ready` stays high and `rd_data` changes to the held word.
- R9: A word that completes while the buffer is full, `ready` is high and no read is taken is discarded. `overrun` is then set and stays set until reset, and `rd_data` is unchanged.
- R10: A strobe that arrives before the last bit of a word is ignored. A strobe on the last-bit edge starts the next frame when `cfg_delay` is 1 or more, giving back-to-back words. A strobe on the last-bit edge is ignored when `cfg_delay` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Receive bit clock; all state changes on its falling edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame strobe, active high |
| sdata | input | 1 | Serial data line |
| cfg_delay | input | 2 | Bit clocks between strobe and first data bit (0..2; 3 acts as 2) |
| cfg_wlen | input | 6 | Word length in bits, limited to 8..32 |
| cfg_sign_ext | input | 1 | 1 = copy the top word bit into the upper bits, 0 = fill with zeros |
| rd_en | input | 1 | Host read strobe for the output register |
| rd_data | output | 32 | Justified output register |
| ready | output | 1 | Output register holds an unread word |
| overrun | output | 1 | Sticky flag: a word was lost |

## Verification
Two events can land on the same falling edge: a host read and the completion of a new word while the buffer is already occupied. The buffer must then move into the output register while the new word takes its place, and no overrun may be recorded. The bench provokes this by running two frames back to back without reading. It then asserts `rd_en` exactly on the last bit of a third frame. It judges the result by checking that `overrun` stays low and that the next two reads return the second and third words in order. The opposite case also runs: the same third word arrives with no read. That run must set the sticky flag and leave the output register holding the first word.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SHIFT = 2'd2
  } srx_state_e;

  // Keep a requested word length inside the supported window.
  function automatic int clamp_len(input int raw, input int lo, input int hi);
    if (raw < lo)      return lo;
    else if (raw > hi) return hi;
    else               return raw;
  endfunction

endpackage

// File: rtl/srx_framer.sv
module srx_framer
  import srx_pkg::*;
#(
  parameter int DW = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          sdata,
  input  logic [1:0]    cfg_delay,
  input  logic [LW-1:0] wlen,
  output logic          word_done,
  output logic [DW-1:0] word_val
);

  srx_state_e    st;
  logic [LW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic [1:0]    dly;
  logic          last_bit;
  logic          sync_ok;

  assign dly       = (cfg_delay > 2'd2) ? 2'd2 : cfg_delay;
  assign last_bit  = (st == ST_SHIFT) && (cnt == wlen - 1'b1);
  assign sync_ok   = fsync && ((st == ST_IDLE) || (last_bit && (dly != 2'd0)));
  assign word_done = last_bit;
  assign word_val  = {shreg[DW-2:0], sdata};

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      shreg <= '0;
    end else if (sync_ok) begin
      case (dly)
        2'd0: begin
          st    <= ST_SHIFT;
          cnt   <= LW'(1);
          shreg <= {{(DW-1){1'b0}}, sdata};
        end
        2'd1: begin
          st    <= ST_SHIFT;
          cnt   <= '0;
          shreg <= '0;
        end
        default: begin
          st    <= ST_WAIT;
          cnt   <= '0;
          shreg <= '0;
        end
      endcase
    end else begin
      case (st)
        ST_WAIT:  st <= ST_SHIFT;
        ST_SHIFT: begin
          if (last_bit) begin
            st <= ST_IDLE;
          end else begin
            shreg <= {shreg[DW-2:0], sdata};
            cnt   <= cnt + 1'b1;
          end
        end
        default:  st <= ST_IDLE;
      endcase
    end
  end

  AST_MIDWORD_SYNC_IGNORED: assert property (@(negedge clk) disable iff (!rst_n)
    (st == ST_SHIFT && !last_bit && fsync) |=> (st == ST_SHIFT && cnt == $past(cnt) + 1'b1)); // R10

  AST_DELAY1_START: assert property (@(negedge clk) disable iff (!rst_n)
    (st == ST_IDLE && fsync && cfg_delay == 2'd1) |=> (st == ST_SHIFT && cnt == '0)); // R3

  AST_DELAY0_LAST_SYNC: assert property (@(negedge clk) disable iff (!rst_n)
    (last_bit && fsync && cfg_delay == 2'd0) |=> (st == ST_IDLE)); // R10

endmodule

// File: rtl/srx_stage.sv
module srx_stage #(
  parameter int DW = 32,
  parameter int LW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_done,
  input  logic [DW-1:0] word_val,
  input  logic          rd_en,
  input  logic          sign_ext,
  input  logic [LW-1:0] wlen,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          overrun
);

  localparam int IW = $clog2(DW);

  logic [DW-1:0] bufr;
  logic          buf_full;
  logic          drr_free;
  logic          move;
  logic          ovr_event;

  // Right-justify a word of len bits and fill the bits above it.
  function automatic logic [DW-1:0] justify(input logic [DW-1:0] w,
                                            input logic [LW-1:0] len,
                                            input logic          sx);
    logic [DW-1:0] m;
    logic [DW-1:0] r;
    m = (int'(len) >= DW) ? '1 : ((DW'(1) << len) - DW'(1));
    r = w & m;
    if (sx && w[IW'(len - 1'b1)]) r = r | ~m;
    return r;
  endfunction

  assign drr_free  = !ready || rd_en;
  assign move      = buf_full && drr_free;
  assign ovr_event = word_done && buf_full && !drr_free;

  always_ff @(negedge clk) begin
    if (!rst_n) begin
      bufr     <= '0;
      buf_full <= 1'b0;
      rd_data  <= '0;
      ready    <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (move) begin
        rd_data <= justify(bufr, wlen, sign_ext);
        ready   <= 1'b1;
      end else if (rd_en) begin
        ready   <= 1'b0;
      end

      if (word_done && !ovr_event) begin
        bufr     <= word_val;
        buf_full <= 1'b1;
      end else if (move) begin
        buf_full <= 1'b0;
      end

      if (ovr_event) overrun <= 1'b1;
    end
  end

  AST_READY_AFTER_COPY: assert property (@(negedge clk) disable iff (!rst_n)
    (buf_full && drr_free) |=> ready); // R5

  AST_READ_CLEARS: assert property (@(negedge clk) disable iff (!rst_n)
    (rd_en && ready && !buf_full) |=> !ready); // R7

  AST_OVERRUN_STICKY: assert property (@(negedge clk) disable iff (!rst_n)
    overrun |=> overrun); // R9

  AST_OVERRUN_KEEPS_DATA: assert property (@(negedge clk) disable iff (!rst_n)
    (word_done && buf_full && ready && !rd_en) |=> ($stable(rd_data) && overrun)); // R9

endmodule

// File: rtl/serial_rx_port.sv
module serial_rx_port #(
  parameter int DW   = 32,
  parameter int MINW = 8,
  localparam int LW  = $clog2(DW + 1)
) (
  input  logic          rx_clk,
  input  logic          rst_n,
  input  logic          fsync,
  input  logic          sdata,
  input  logic [1:0]    cfg_delay,
  input  logic [LW-1:0] cfg_wlen,
  input  logic          cfg_sign_ext,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          ready,
  output logic          overrun
);

  logic [LW-1:0] wlen_eff;
  logic          word_done;
  logic [DW-1:0] word_val;

  assign wlen_eff = LW'(srx_pkg::clamp_len(int'(cfg_wlen), MINW, DW));

  srx_framer #(.DW(DW), .LW(LW)) u_framer (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .fsync     (fsync),
    .sdata     (sdata),
    .cfg_delay (cfg_delay),
    .wlen      (wlen_eff),
    .word_done (word_done),
    .word_val  (word_val)
  );

  srx_stage #(.DW(DW), .LW(LW)) u_stage (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .word_done (word_done),
    .word_val  (word_val),
    .rd_en     (rd_en),
    .sign_ext  (cfg_sign_ext),
    .wlen      (wlen_eff),
    .rd_data   (rd_data),
    .ready     (ready),
    .overrun   (overrun)
  );

  AST_LEN_IN_RANGE: assert property (@(negedge rx_clk) disable iff (!rst_n)
    (int'(wlen_eff) >= MINW && int'(wlen_eff) <= DW)); // R4

endmodule

// File: tb/sim_serial_rx_port.sv
module sim_serial_rx_port;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        sdata = 1'b0;
  logic [1:0]  cfg_delay = 2'd1;
  logic [5:0]  cfg_wlen = 6'd16;
  logic        cfg_sign_ext = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        ready;
  logic        overrun;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_rx_port u0 (
    .rx_clk(clk), .rst_n(rst_n), .fsync(fsync), .sdata(sdata),
    .cfg_delay(cfg_delay), .cfg_wlen(cfg_wlen), .cfg_sign_ext(cfg_sign_ext),
    .rd_en(rd_en), .rd_data(rd_data), .ready(ready), .overrun(overrun)
  );

  // Expected output word: each bit chosen by position, independent of masks.
  function automatic logic [31:0] exp_word(input logic [31:0] w, input int len, input bit sx);
    logic [31:0] r;
    for (int i = 0; i < 32; i++)
      r[i] = (i < len) ? w[i] : (sx ? w[len-1] : 1'b0);
    return r;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Present inputs at a rising edge; return after the falling edge has used them.
  task automatic cyc(input logic fs, input logic sd, input logic rd);
    fsync = fs; sdata = sd; rd_en = rd;
    @(negedge clk);
    @(posedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(0, 0, 0);
    cyc(0, 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 1'($urandom), 0);
  endtask

  task automatic send(input logic [31:0] w, input int len, input int d,
                      input bit presynced, input bit sync_mid,
                      input bit sync_last, input bit rd_last);
    int deff;
    int total;
    logic fs, sd, rd;
    deff  = (d > 2) ? 2 : d;
    total = deff + len;
    for (int k = (presynced ? 1 : 0); k < total; k++) begin
      fs = (k == 0) || (sync_mid && k == deff + len/2) || (sync_last && k == total - 1);
      sd = (k >= deff) ? w[len-1-(k-deff)] : 1'($urandom);
      rd = rd_last && (k == total - 1);
      cyc(fs, sd, rd);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] wa, wb, wc;
    int len, d;
    bit sx;
    void'($urandom(32'd2024));
    @(posedge clk);
    do_reset();
    // R1 reset state
    chk("R1", "ready after reset", 32'(ready), 32'd0);
    chk("R1", "overrun after reset", 32'(overrun), 32'd0);
    chk("R1", "rd_data after reset", rd_data, 32'd0);

    // R2: no strobe, no word
    idle(40);
    chk("R2", "ready without strobe", 32'(ready), 32'd0);

    // Random frames: delay R3, length and order R4, timing R5, fill R6, read R7
    for (int i = 0; i < 30; i++) begin
      len = 8 + int'($urandom % 25);
      d   = int'($urandom % 4);
      sx  = 1'($urandom);
      wa  = $urandom;
      if (i < 4) wa[len-1] = 1'b1;
      cfg_wlen = 6'(len); cfg_delay = 2'(d); cfg_sign_ext = sx;
      idle(int'($urandom % 4));
      send(wa, len, d, 0, 0, 0, 0);
      chk("R5", "ready on last-bit edge", 32'(ready), 32'd0);
      cyc(0, 1'($urandom), 0);
      chk("R5", "ready one edge later", 32'(ready), 32'd1);
      chk("R3 R4 R6", "word value", rd_data, exp_word(wa, len, sx));
      cyc(0, 1'($urandom), 1);
      chk("R7", "ready after read", 32'(ready), 32'd0);
      cyc(0, 1'($urandom), 1);
      chk("R7", "read while empty keeps data", rd_data, exp_word(wa, len, sx));
    end
    chk("R9", "no overrun in paced traffic", 32'(overrun), 32'd0);

    // R4 length clamping
    cfg_delay = 2'd1; cfg_sign_ext = 1'b1;
    cfg_wlen = 6'd5; wa = 32'h0000_00A5;
    send(wa, 8, 1, 0, 0, 0, 0); cyc(0, 0, 0);
    chk("R4", "short length acts as 8", rd_data, exp_word(wa, 8, 1));
    cyc(0, 0, 1);
    cfg_wlen = 6'd63; wa = 32'h8123_4567;
    send(wa, 32, 1, 0, 0, 0, 0); cyc(0, 0, 0);
    chk("R4", "long length acts as 32", rd_data, wa);
    cyc(0, 0, 1);

    // R10: strobe in the middle of a word is ignored
    cfg_wlen = 6'd20; cfg_delay = 2'd2; cfg_sign_ext = 1'b0; wa = 32'h000C_3A5F;
    send(wa, 20, 2, 0, 1, 0, 0); cyc(0, 0, 0);
    chk("R10", "mid-word strobe ignored", rd_data, exp_word(wa, 20, 0));
    cyc(0, 0, 1);
    chk("R10", "no extra word after mid strobe", 32'(ready), 32'd0);

    // R10: strobe on last bit with delay 0 is ignored
    cfg_delay = 2'd0; cfg_wlen = 6'd12; wa = 32'h0000_0ABC;
    send(wa, 12, 0, 0, 0, 1, 0);
    idle(40);
    chk("R10", "delay0 word value", rd_data, exp_word(wa, 12, 0));
    cyc(0, 0, 1);
    chk("R10", "delay0 last-bit strobe ignored", 32'(ready), 32'd0);

    // R8 and R9: back-to-back words, then overrun
    do_reset();
    cfg_delay = 2'd1; cfg_wlen = 6'd16; cfg_sign_ext = 1'b0;
    wa = 32'h0000_1234; wb = 32'h0000_BEEF; wc = 32'h0000_7777;
    send(wa, 16, 1, 0, 0, 1, 0);
    send(wb, 16, 1, 1, 0, 0, 0);
    cyc(0, 0, 0);
    chk("R8", "first word shown while second held", rd_data, wa);
    send(wc, 16, 1, 0, 0, 0, 0);
    chk("R9", "overrun set", 32'(overrun), 32'd1);
    chk("R9", "data kept on overrun", rd_data, wa);
    cyc(0, 0, 1);
    chk("R8", "ready stays after read", 32'(ready), 32'd1);
    chk("R8", "held word moves in", rd_data, wb);
    cyc(0, 0, 1);
    chk("R7", "ready clears after last read", 32'(ready), 32'd0);
    idle(5);
    chk("R9", "overrun sticky", 32'(overrun), 32'd1);
    do_reset();
    chk("R1", "reset clears overrun", 32'(overrun), 32'd0);
    chk("R1", "reset clears ready", 32'(ready), 32'd0);

    // Read and word completion on the same edge with buffer full
    send(wa, 16, 1, 0, 0, 1, 0);
    send(wb, 16, 1, 1, 0, 0, 0);
    cyc(0, 0, 0);
    send(wc, 16, 1, 0, 0, 0, 1);
    chk("R8", "collision: held word moved", rd_data, wb);
    chk("R9", "collision: no overrun", 32'(overrun), 32'd0);
    cyc(0, 0, 0);
    cyc(0, 0, 1);
    chk("R8", "collision: third word follows", rd_data, wc);
    cyc(0, 0, 1);
    chk("R7", "collision: drained", 32'(ready), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule